// File: doc/BRIEF.md
# Power-Management Command and Scratch Byte Port

This block decodes a two-byte window on the processor I/O bus. The even address of the window is a command byte and the odd address next to it is a scratch status byte. Software reads back each byte as it last wrote it. A write to the command byte also notifies the firmware. In the normal mode, every such write raises a one-cycle system-management interrupt request toward the processor.

A mode input selects a fallback path for systems that have no firmware handler. In that path, the block decodes the command byte in hardware. One code requests that the SCI enable flag be cleared, and another requests that it be set. Each request goes out as a one-cycle strobe to the power-management unit, which owns the flag itself.

The bus side is a single-cycle request with a write-enable. A read returns its data one cycle after the request, marked by a valid flag. Reset is synchronous and active high.

Top module: `apm_cmd_port`

## Requirements
- R1: While reset is held and in the cycle after it is released, io_rvalid, smi_pulse, sci_set and sci_clr are 0. Both bytes read back 0x00 after reset.
- R2: Only addresses whose bits above bit 0 match BASE_ADDR (default 0x00B2) are decoded. A request to any other address stores nothing, raises no strobe and gives no io_rvalid.
- R3: A write with address bit 0 = 0 (default 0x00B2) stores io_wdata in the command byte.
- R4: A write with address bit 0 = 1 (default 0x00B3) stores io_wdata in the status byte. It raises no smi_pulse, sci_set or sci_clr and leaves the command byte unchanged.
- R5: With fallback_mode = 0, every command-byte write drives smi_pulse high for exactly the cycle after the write. Two writes of the same value give two pulses.
- R6: With fallback_mode = 1, a command-byte write of 0xF1 drives sci_set high for the cycle after the write, and a write of 0xF0 drives sci_clr high for that cycle. No smi_pulse is raised in this mode.
- R7: In fallback mode, any other command code raises no strobe and is still stored. With fallback_mode = 0, codes 0xF0 and 0xF1 raise no SCI strobe.
- R8: A read request (io_we = 0) inside the window drives io_rvalid high in the next cycle, with io_rdata holding the addressed byte. A read changes no stored byte and raises no strobe.
- R9: sci_set and sci_clr are never high together, and smi_pulse is never high together with either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_req | input | 1 | Bus request valid for this cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | I/O byte address |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after a decoded read |
| fallback_mode | input | 1 | 0 = raise SMI on command write, 1 = decode SCI codes |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |
| sci_set | output | 1 | One-cycle request to set the SCI enable flag |
| sci_clr | output | 1 | One-cycle request to clear the SCI enable flag |

## Verification
Every result of this block is due exactly one clock after the request that causes it. This covers read data with its valid flag, the SMI pulse and both SCI strobes. For each request cycle, and for each idle cycle, the driver queues one expected output vector. The monitor pops one vector at each following falling edge and compares all outputs. A strobe that comes early, comes late or lasts two cycles therefore shows up as a mismatch on a neighbouring vector. Back-to-back writes of the same command code, and reads placed right after writes, exercise these cycle boundaries directly.

// File: rtl/apm_pkg.sv
package apm_pkg;

  typedef enum logic [1:0] {
    APM_ACT_NONE    = 2'd0,
    APM_ACT_SCI_ON  = 2'd1,
    APM_ACT_SCI_OFF = 2'd2
  } apm_act_e;

  // Map a command byte to a fallback action.
  function automatic apm_act_e apm_decode_cmd(
    input logic [7:0] code,
    input logic [7:0] on_code,
    input logic [7:0] off_code
  );
    if (code == on_code)       return APM_ACT_SCI_ON;
    else if (code == off_code) return APM_ACT_SCI_OFF;
    else                       return APM_ACT_NONE;
  endfunction

endpackage

// File: rtl/apm_addr_dec.sv
module apm_addr_dec #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00B2
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_wr,
  output logic              sts_wr,
  output logic              rd_hit,
  output logic              rd_sel
);
  localparam int PAIR_W = ADDR_W - 1;
  localparam logic [PAIR_W-1:0] PAIR_TAG = BASE_ADDR[ADDR_W-1:1];

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:1] == PAIR_TAG;
  endfunction

  logic hit;
  assign hit    = req && in_window(addr);
  assign cmd_wr = hit && we && !addr[0];
  assign sts_wr = hit && we && addr[0];
  assign rd_hit = hit && !we;
  assign rd_sel = addr[0];

  initial begin
    if (BASE_ADDR[0] != 1'b0) $display("apm_addr_dec: BASE_ADDR must be even");
  end
endmodule

// File: rtl/apm_regs.sv
module apm_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              sts_wr,
  input  logic              rd_hit,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int NREG = 2;

  logic [NREG-1:0]   wr_vec;
  logic [DATA_W-1:0] reg_q [NREG];

  assign wr_vec = {sts_wr, cmd_wr};

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)            reg_q[g] <= '0;
      else if (wr_vec[g]) reg_q[g] <= wdata;
    end
  end

  assign cmd_q = reg_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_hit;
      if (rd_hit) rdata <= reg_q[rd_sel];
    end
  end

  // R3
  cmd_store_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> reg_q[0] == $past(wdata));
  // R4
  sts_keeps_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && !cmd_wr) |=> $stable(reg_q[0]));
  // R8
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rvalid);
  // R8
  read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !cmd_wr && !sts_wr) |=> ($stable(reg_q[0]) && $stable(reg_q[1])));
endmodule

// File: rtl/apm_event_gen.sv
module apm_event_gen
  import apm_pkg::*;
#(
  parameter int         DATA_W       = 8,
  parameter logic [7:0] CODE_SCI_ON  = 8'hF1,
  parameter logic [7:0] CODE_SCI_OFF = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fallback_mode,
  output logic              smi_pulse,
  output logic              sci_set,
  output logic              sci_clr
);
  apm_act_e act;
  logic     fb_wr;
  logic     smi_wr;

  assign act    = apm_decode_cmd(wdata[7:0], CODE_SCI_ON, CODE_SCI_OFF);
  assign fb_wr  = cmd_wr && fallback_mode;
  assign smi_wr = cmd_wr && !fallback_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_pulse <= 1'b0;
      sci_set   <= 1'b0;
      sci_clr   <= 1'b0;
    end else begin
      smi_pulse <= smi_wr;
      sci_set   <= fb_wr && (act == APM_ACT_SCI_ON);
      sci_clr   <= fb_wr && (act == APM_ACT_SCI_OFF);
    end
  end

  // R5
  smi_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    smi_wr |=> smi_pulse);
  // R5
  smi_only_write_chk: assert property (@(posedge clk) disable iff (rst)
    !smi_wr |=> !smi_pulse);
  // R6
  no_smi_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    fb_wr |=> !smi_pulse);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({smi_pulse, sci_set, sci_clr}) <= 1);
endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port #(
  parameter int                ADDR_W       = 16,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h00B2,
  parameter logic [7:0]        CODE_SCI_ON  = 8'hF1,
  parameter logic [7:0]        CODE_SCI_OFF = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  input  logic              fallback_mode,
  output logic              smi_pulse,
  output logic              sci_set,
  output logic              sci_clr
);
  logic              cmd_wr;
  logic              sts_wr;
  logic              rd_hit;
  logic              rd_sel;
  logic [DATA_W-1:0] cmd_q;

  apm_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .req(io_req), .we(io_we), .addr(io_addr),
    .cmd_wr(cmd_wr), .sts_wr(sts_wr), .rd_hit(rd_hit), .rd_sel(rd_sel)
  );

  apm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .sts_wr(sts_wr),
    .rd_hit(rd_hit), .rd_sel(rd_sel), .wdata(io_wdata),
    .cmd_q(cmd_q), .rdata(io_rdata), .rvalid(io_rvalid)
  );

  apm_event_gen #(
    .DATA_W(DATA_W), .CODE_SCI_ON(CODE_SCI_ON), .CODE_SCI_OFF(CODE_SCI_OFF)
  ) u_evt (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .wdata(io_wdata),
    .fallback_mode(fallback_mode),
    .smi_pulse(smi_pulse), .sci_set(sci_set), .sci_clr(sci_clr)
  );

  // R2
  miss_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr && !sts_wr && !rd_hit) |=> (!io_rvalid && !smi_pulse && !sci_set && !sci_clr));
  // R4
  sts_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && !cmd_wr) |=> (!smi_pulse && !sci_set && !sci_clr && $stable(cmd_q)));
endmodule

// File: tb/test_apm_cmd_port.sv
module test_apm_cmd_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0;
  logic        io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        fallback_mode = 1'b0;
  logic        smi_pulse;
  logic        sci_set;
  logic        sci_clr;

  always #2.5 clk = ~clk;

  apm_cmd_port i_apm_cmd_port (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .fallback_mode(fallback_mode), .smi_pulse(smi_pulse),
    .sci_set(sci_set), .sci_clr(sci_clr)
  );

  typedef struct {
    logic       rv;
    logic [7:0] rd;
    logic       smi;
    logic       set;
    logic       clr;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         mon_on = 1'b0;
  bit         done = 1'b0;
  logic [7:0] m_cmd = 8'h00;
  logic [7:0] m_sts = 8'h00;

  task automatic drive(input logic req, input logic we, input logic [15:0] a,
                       input logic [7:0] d, input logic fb, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk); #1;
    io_req = req; io_we = we; io_addr = a; io_wdata = d; fallback_mode = fb;
    hit = req && (a[15:1] == 15'h0059);
    e.rv = 1'b0; e.rd = 8'h00; e.smi = 1'b0; e.set = 1'b0; e.clr = 1'b0; e.req = tag;
    if (hit && !we) begin
      e.rv = 1'b1;
      e.rd = a[0] ? m_sts : m_cmd;
    end
    if (hit && we) begin
      if (a[0]) m_sts = d;
      else begin
        m_cmd = d;
        if (!fb) e.smi = 1'b1;
        else if (d == 8'hF1) e.set = 1'b1;
        else if (d == 8'hF0) e.clr = 1'b1;
      end
    end
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic fb, input string tag);
    drive(1'b1, 1'b1, a, d, fb, tag);
  endtask
  task automatic rd(input logic [15:0] a, input string tag);
    drive(1'b1, 1'b0, a, 8'h00, fallback_mode, tag);
  endtask
  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 16'h0000, 8'h00, fallback_mode, tag);
  endtask

  // monitor: one expected vector per cycle, compared at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (io_rvalid !== e.rv || smi_pulse !== e.smi || sci_set !== e.set ||
            sci_clr !== e.clr || (e.rv && io_rdata !== e.rd)) begin
          n_bad++;
          $display("FAIL %s: got rv=%b rd=%02h smi=%b set=%b clr=%b exp rv=%b rd=%02h smi=%b set=%b clr=%b",
                   e.req, io_rvalid, io_rdata, smi_pulse, sci_set, sci_clr,
                   e.rv, e.rd, e.smi, e.set, e.clr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet while reset is held, even with a write presented
    io_req = 1'b1; io_we = 1'b1; io_addr = 16'h00B2; io_wdata = 8'h5A;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (io_rvalid !== 1'b0 || smi_pulse !== 1'b0 || sci_set !== 1'b0 || sci_clr !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs: got %b%b%b%b exp 0000", io_rvalid, smi_pulse, sci_set, sci_clr);
    end
    #1; io_req = 1'b0; io_we = 1'b0;
    @(negedge clk); #1;
    rst = 1'b0;
    mon_on = 1'b1;
    idle("R1 first cycle after reset");
    rd(16'h00B2, "R1 cmd reset value");
    rd(16'h00B3, "R1 sts reset value");
    idle("R1 idle");

    // R3 / R5: store and SMI in normal mode
    wr(16'h00B2, 8'h3C, 1'b0, "R5 smi on cmd write");
    rd(16'h00B2, "R3 cmd readback");
    wr(16'h00B2, 8'h77, 1'b0, "R5 first pulse");
    wr(16'h00B2, 8'h77, 1'b0, "R5 second pulse same value");
    idle("R5 pulse ends");
    rd(16'h00B2, "R3 cmd readback 77");

    // R4: status byte
    wr(16'h00B3, 8'hA5, 1'b0, "R4 sts write no event");
    rd(16'h00B3, "R4 sts readback");
    rd(16'h00B2, "R4 cmd unchanged");
    wr(16'h00B3, 8'hF1, 1'b1, "R4 sts F1 fallback no event");
    rd(16'h00B3, "R4 sts readback F1");

    // R2: misses
    wr(16'h00B4, 8'h11, 1'b0, "R2 miss above window");
    wr(16'h01B2, 8'h22, 1'b0, "R2 miss high bit");
    wr(16'h00B0, 8'hF1, 1'b1, "R2 miss below window fallback");
    rd(16'h00B4, "R2 miss read no valid");
    rd(16'h00B2, "R2 cmd untouched by misses");
    rd(16'h00B3, "R2 sts untouched by misses");

    // R6 / R7 fallback decode
    wr(16'h00B2, 8'hF1, 1'b1, "R6 set strobe");
    wr(16'h00B2, 8'hF0, 1'b1, "R6 clr strobe");
    wr(16'h00B2, 8'hF0, 1'b1, "R6 clr strobe again");
    wr(16'h00B2, 8'hF2, 1'b1, "R7 other code no strobe");
    rd(16'h00B2, "R7 other code stored");
    wr(16'h00B2, 8'h00, 1'b1, "R7 zero code no strobe");
    wr(16'h00B2, 8'hF1, 1'b0, "R7 F1 in smi mode gives smi only");
    wr(16'h00B2, 8'hF0, 1'b0, "R7 F0 in smi mode gives smi only");
    rd(16'h00B2, "R8 read after write");
    rd(16'h00B3, "R8 second read");
    rd(16'h00B3, "R8 read no side effect");
    idle("R9 quiet");
    idle("R9 quiet");
    idle("drain");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule